// File: doc/BRIEF.md
# Single-Accumulator Processor with Interrupt Entry

This block is a minimal processor built around a single accumulator. Code and data share one synchronous read/write memory. The block reaches that memory through registered address, write-data, write-enable and read-strobe outputs. Each instruction word is 16 bits wide. The upper 4 bits select the operation and the lower 12 bits give a memory address. Every instruction is handled as a fixed chain of states: fetch, decode, an optional operand read or store, execute, and a final interrupt check.

The interrupt check is the last state of every instruction. If a request has been latched and interrupts are enabled, the block does four things: it copies the program counter into an internal shadow register, loads the handler address, clears the enable and pulses an acknowledge. A return instruction copies the shadow register back into the program counter and sets the enable again. A request that arrives while the handler runs is held until the return.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high, `mem_re`, `mem_we` and `irq_ack` are low. After `rst` falls, the first read strobe carries address 0x300.
- R2: Each fetch issues a one-cycle read at the program counter. Without a taken jump or interrupt, the next fetch address is that value plus 1, modulo 4096. Instruction word layout is bits [15:12] opcode and bits [11:0] address. For loads and adds, the next fetch strobe comes 7 cycles after the current one; for all other opcodes it comes 6 cycles after.
- R3: Opcode 0x1 copies the word at the address field into the accumulator. Its operand read strobe comes 3 cycles after the instruction's fetch strobe.
- R4: Opcode 0x5 adds the word at the address field to the accumulator, modulo 2^16.
- R5: Opcode 0x2 writes the accumulator to the address field with a single-cycle `mem_we`. That strobe comes 3 cycles after the fetch strobe.
- R6: Opcode 0x8 makes the next fetch come from the address field.
- R7: Every opcode other than 0x1, 0x2, 0x5, 0x8 and 0xF leaves the accumulator unchanged. It reads and writes no memory and is followed by a fetch at PC+1.
- R8: A request is an `irq` level sampled high at a clock edge. It is taken at the end of the current instruction when interrupts are enabled. `irq_ack` then pulses for one cycle, and in the next cycle a fetch strobe is issued at 0x010.
- R9: Requests that arrive while a handler runs are latched, not taken. They are taken right after the return instruction completes.
- R10: Opcode 0xF resumes fetching at the program counter that was saved when the interrupt was taken. It also re-enables interrupts.
- R11: `mem_re` and `mem_we` are never high together, and each stays high for one cycle only.
- R12: The program 0x1940, 0x5941, 0x2941 at 0x300 leaves 5 at 0x941 when 0x940 holds 3 and 0x941 holds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address (registered) |
| mem_wdata | output | 16 | Memory write data (registered) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the strobe cycle |
| mem_we | output | 1 | Memory write enable, one cycle |
| mem_re | output | 1 | Memory read strobe, one cycle |
| irq | input | 1 | Interrupt request, sampled each edge |
| irq_ack | output | 1 | One-cycle pulse when a request is taken |

## Verification
The bench records the cycle number of every read and write strobe. It checks the spacing of those numbers:
- An operand read or a store write lands 3 cycles after its fetch strobe.
- The next fetch lands 6 or 7 cycles after the current fetch, depending on the opcode.
- A vector fetch lands 1 cycle after the acknowledge.

Memory results and the order of read addresses are compared only after the program has settled in its closing self-jump. Interrupt pulses are driven at falling edges, keyed to observed strobe addresses, so each request falls in a known state of the instruction in progress.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  typedef enum logic [2:0] {
    ST_FADDR, ST_FWAIT, ST_FLOAD, ST_DEC,
    ST_OWAIT, ST_STORE, ST_EXEC, ST_ICHK
  } state_t;

  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_ADD   = 4'h5;
  localparam logic [3:0] OP_JUMP  = 4'h8;
  localparam logic [3:0] OP_RETI  = 4'hF;
endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] opcode,
  output state_t     state
);
  state_t nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_FADDR: nxt = ST_FWAIT;
      ST_FWAIT: nxt = ST_FLOAD;
      ST_FLOAD: nxt = ST_DEC;
      ST_DEC: begin
        if (opcode == OP_LOAD || opcode == OP_ADD) nxt = ST_OWAIT;
        else if (opcode == OP_STORE)               nxt = ST_STORE;
        else                                       nxt = ST_EXEC;
      end
      ST_OWAIT: nxt = ST_EXEC;
      ST_STORE: nxt = ST_ICHK;
      ST_EXEC:  nxt = ST_ICHK;
      default:  nxt = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_FADDR;
    else     state <= nxt;
  end
endmodule

// File: rtl/acc_cpu_irq.sv
module acc_cpu_irq
  import acc_cpu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       irq,
  input  state_t     state,
  input  logic [3:0] opcode,
  output logic       take,
  output logic       ack
);
  logic pending;
  logic enabled;

  assign take = (state == ST_ICHK) && pending && enabled;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      enabled <= 1'b1;
      ack     <= 1'b0;
    end else begin
      pending <= take ? 1'b0 : (pending | irq);
      ack     <= take;
      if (take)
        enabled <= 1'b0;
      else if (state == ST_EXEC && opcode == OP_RETI)
        enabled <= 1'b1;
    end
  end
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 16,
  parameter logic [11:0] RESET_PC = 12'h300,
  parameter logic [11:0] VECTOR   = 12'h010
) (
  input  logic              clk,
  input  logic              rst,
  input  state_t            state,
  input  logic              take,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [3:0]        opcode,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re
);
  logic [ADDR_W-1:0] pc, shadow;
  logic [DATA_W-1:0] ir, acc;
  logic [ADDR_W-1:0] field;

  assign opcode = ir[DATA_W-1 -: 4];
  assign field  = ir[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      pc        <= RESET_PC[ADDR_W-1:0];
      shadow    <= '0;
      ir        <= '0;
      acc       <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
    end else begin
      mem_re <= 1'b0;
      mem_we <= 1'b0;
      case (state)
        ST_FADDR: begin
          mem_addr <= pc;
          mem_re   <= 1'b1;
        end
        ST_FLOAD: begin
          ir <= mem_rdata;
          pc <= pc + 1'b1;
        end
        ST_DEC: begin
          mem_addr <= field;
          if (opcode == OP_LOAD || opcode == OP_ADD) mem_re <= 1'b1;
          if (opcode == OP_STORE) begin
            mem_we    <= 1'b1;
            mem_wdata <= acc;
          end
        end
        ST_EXEC: begin
          case (opcode)
            OP_LOAD: acc <= mem_rdata;
            OP_ADD:  acc <= acc + mem_rdata;
            OP_JUMP: pc  <= field;
            OP_RETI: pc  <= shadow;
            default: ;
          endcase
        end
        ST_ICHK: begin
          if (take) begin
            shadow <= pc;
            pc     <= VECTOR[ADDR_W-1:0];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 16,
  parameter logic [11:0] RESET_PC = 12'h300,
  parameter logic [11:0] VECTOR   = 12'h010
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic              irq,
  output logic              irq_ack
);
  state_t     state;
  logic [3:0] opcode;
  logic       take;

  acc_cpu_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .state(state)
  );

  acc_cpu_irq u_irq (
    .clk(clk), .rst(rst), .irq(irq), .state(state),
    .opcode(opcode), .take(take), .ack(irq_ack)
  );

  acc_cpu_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_PC(RESET_PC), .VECTOR(VECTOR)
  ) u_dp (
    .clk(clk), .rst(rst), .state(state), .take(take),
    .mem_rdata(mem_rdata), .opcode(opcode), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re)
  );
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int          ADDR_W = 12,
  parameter logic [11:0] VECTOR = 12'h010
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              irq_ack
);
  a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));

  a_r11_read_single: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re);

  a_r5_write_single: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);

  a_r8_vector_fetch: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> (mem_re && mem_addr == VECTOR[ADDR_W-1:0]));
endmodule

bind acc_cpu acc_cpu_chk #(.ADDR_W(ADDR_W), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_we(mem_we),
  .mem_re(mem_re), .irq_ack(irq_ack)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_we, mem_re;
  logic        irq = 1'b0;
  logic        irq_ack;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, total = 0;
  logic [15:0] mem [0:4095];
  logic [11:0] rd_addr [0:255];
  int          rd_cyc  [0:255];
  int          rd_n;
  logic [11:0] wr_addr [0:63];
  logic [15:0] wr_data [0:63];
  int          wr_cyc  [0:63];
  int          wr_n, ack_n;
  logic        t1_en, t2_en;
  logic [11:0] t1_addr, t2_addr;

  always #2 clk = ~clk;

  acc_cpu u_dut (
    .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_re(mem_re),
    .irq(irq), .irq_ack(irq_ack)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
    cyc   <= cyc + 1;
    total <= total + 1;
  end

  always @(negedge clk) begin
    irq = 1'b0;
    if (!rst) begin
      if (mem_re && rd_n < 256) begin
        rd_addr[rd_n] = mem_addr; rd_cyc[rd_n] = cyc; rd_n++;
        if (t1_en && mem_addr == t1_addr) begin irq = 1'b1; t1_en = 1'b0; end
        if (t2_en && mem_addr == t2_addr) begin irq = 1'b1; t2_en = 1'b0; end
      end
      if (mem_we && wr_n < 64) begin
        wr_addr[wr_n] = mem_addr; wr_data[wr_n] = mem_wdata; wr_cyc[wr_n] = cyc; wr_n++;
      end
      if (irq_ack) ack_n++;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
  endtask

  task automatic run(int n);
    rst = 1'b1; rd_n = 0; wr_n = 0; ack_n = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic cmp_reads(string req, logic [11:0] e[$]);
    for (int i = 0; i < e.size(); i++) chk(req, {20'h0, rd_addr[i]}, {20'h0, e[i]});
  endtask

  initial begin
    t1_en = 1'b0; t2_en = 1'b0; t1_addr = '0; t2_addr = '0;
    rd_n = 0; wr_n = 0; ack_n = 0;

    // R1: reset outputs
    repeat (3) @(negedge clk);
    chk("R1 re in reset", {31'h0, mem_re}, 32'h0);
    chk("R1 we in reset", {31'h0, mem_we}, 32'h0);
    chk("R1 ack in reset", {31'h0, irq_ack}, 32'h0);

    // R12 reference program, plus R2 R3 R5 timing
    clear_mem();
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941; mem[12'h302] = 16'h2941;
    mem[12'h303] = 16'h8303; mem[12'h940] = 16'd3; mem[12'h941] = 16'd2;
    run(60);
    chk("R1 first fetch", {20'h0, rd_addr[0]}, 32'h300);
    chk("R12 result", {16'h0, mem[12'h941]}, 32'd5);
    cmp_reads("R2 order", '{12'h300, 12'h940, 12'h301, 12'h941, 12'h302, 12'h303, 12'h303});
    chk("R3 operand lag", rd_cyc[1] - rd_cyc[0], 32'd3);
    chk("R2 load gap", rd_cyc[2] - rd_cyc[0], 32'd7);
    chk("R5 store lag", wr_cyc[0] - rd_cyc[4], 32'd3);
    chk("R2 store gap", rd_cyc[5] - rd_cyc[4], 32'd6);
    chk("R5 write count", wr_n, 32'd1);
    chk("R5 write data", {16'h0, wr_data[0]}, 32'd5);

    // R4 sweep of add operands
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        logic [15:0] va, vb, vals [6];
        vals = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        va = vals[a]; vb = vals[b];
        clear_mem();
        mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941; mem[12'h302] = 16'h2942;
        mem[12'h303] = 16'h8303; mem[12'h940] = va; mem[12'h941] = vb;
        run(45);
        chk("R4 add sum", {16'h0, mem[12'h942]}, {16'h0, 16'(va + vb)});
        chk("R3 load kept", {16'h0, mem[12'h940]}, {16'h0, va});
      end
    end

    // R7 sweep of undefined opcodes
    for (int op = 0; op < 16; op++) begin
      if (op == 1 || op == 2 || op == 5 || op == 8 || op == 15) continue;
      clear_mem();
      mem[12'h300] = 16'h1940; mem[12'h301] = {4'(op), 12'h955};
      mem[12'h302] = 16'h2943; mem[12'h303] = 16'h8303;
      mem[12'h940] = 16'h0007; mem[12'h955] = 16'hBEEF;
      run(45);
      chk("R7 acc kept", {16'h0, mem[12'h943]}, 32'h7);
      chk("R7 no extra write", wr_n, 32'd1);
      cmp_reads("R7 order", '{12'h300, 12'h940, 12'h301, 12'h302, 12'h303});
      chk("R7 gap", rd_cyc[3] - rd_cyc[2], 32'd6);
    end

    // R6 jump
    clear_mem();
    mem[12'h300] = 16'h8500; mem[12'h500] = 16'h1940; mem[12'h501] = 16'h2944;
    mem[12'h502] = 16'h8502; mem[12'h940] = 16'h0009;
    run(45);
    cmp_reads("R6 order", '{12'h300, 12'h500, 12'h940, 12'h501, 12'h502, 12'h502});
    chk("R6 stored", {16'h0, mem[12'h944]}, 32'h9);

    // R8 R10 single interrupt
    clear_mem();
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941; mem[12'h302] = 16'h2947;
    mem[12'h303] = 16'h8303; mem[12'h940] = 16'd3; mem[12'h941] = 16'd2;
    mem[12'h010] = 16'h1945; mem[12'h011] = 16'h2946; mem[12'h012] = 16'hF000;
    mem[12'h945] = 16'h0055;
    t1_addr = 12'h940; t1_en = 1'b1;
    run(90);
    cmp_reads("R8 R10 order", '{12'h300, 12'h940, 12'h010, 12'h945, 12'h011,
                               12'h012, 12'h301, 12'h941, 12'h302, 12'h303});
    chk("R8 ack count", ack_n, 32'd1);
    chk("R8 handler store", {16'h0, mem[12'h946]}, 32'h55);
    chk("R10 resumed add", {16'h0, mem[12'h947]}, 32'h57);

    // R9 request during handler
    clear_mem();
    mem[12'h300] = 16'h1940; mem[12'h301] = 16'h5941; mem[12'h302] = 16'h2947;
    mem[12'h303] = 16'h8303; mem[12'h940] = 16'd3; mem[12'h941] = 16'd2;
    mem[12'h010] = 16'h1945; mem[12'h011] = 16'h2946; mem[12'h012] = 16'hF000;
    mem[12'h945] = 16'h0055;
    t1_addr = 12'h940; t1_en = 1'b1; t2_addr = 12'h011; t2_en = 1'b1;
    run(120);
    cmp_reads("R9 order", '{12'h300, 12'h940, 12'h010, 12'h945, 12'h011, 12'h012,
                           12'h010, 12'h945, 12'h011, 12'h012, 12'h301, 12'h941,
                           12'h302, 12'h303});
    chk("R9 ack count", ack_n, 32'd2);
    chk("R9 writes", wr_n, 32'd3);
    chk("R9 final", {16'h0, mem[12'h947]}, 32'h57);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    if (total > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", total);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule